// File: doc/BRIEF.md
# CORDIC Step Sequencer

This control unit drives an external CORDIC datapath. The host gives it a three-bit function code and a start pulse. From these it plays out an ordered list of step commands held in a 512 x 16 microcode ROM. The two low code bits pick a program sector in the ROM: linear, circular or hyperbolic. The high code bit picks rotation or vectoring. That choice fixes which datapath sign bit, z or y, steers the add/subtract decision for the whole run.

Each microword marks its step as regular, double (a regular step repeated at the same index) or scale-factor, and carries a flag for the final step. A 7-bit micro-address counter walks the sector from its first word. A separate iteration-index counter moves forward only on regular steps, so double and scale steps reuse the index of the regular step just before them. The datapath splits every step into a low half-word pass and a high half-word pass, so the sequencer holds each word for two clocks and reports which half is active.

The ROM contents are computed when the design is built, from short per-mode lists of the indices that take a double or a scale step.

Top module: `cordic_step_seq`

## Requirements
- R1: After reset, busy, done, step_valid, step_phase, step_last and step_idx are all 0.
- R2: func[1:0] picks the program: 00 linear (ITERS words), 01 circular (ITERS+2 words), 10 hyperbolic (ITERS+4 words). step_kind is encoded 00 regular, 01 double, 10 scale; 11 never appears.
- R3: Each word is presented for exactly two clocks, step_phase 0 (low half-word) then 1 (high half-word). step_kind and step_idx hold steady across the pair.
- R4: Regular words carry indices 1, 2, ..., ITERS in order. A double or scale word shows the index of the regular word just before it. The index advances only after a regular word.
- R5: The linear program is made only of regular words.
- R6: The circular program inserts one scale word right after regular index 2 and one right after regular index 4.
- R7: The hyperbolic program inserts a double word right after regular indices 4 and 13, and a scale word right after regular indices 3 and 5. When an index has both, the double word comes first.
- R8: step_last is 1 on both phases of the final word of the program and 0 on every other word.
- R9: sign_y equals func[2] captured at start (0 means the z sign steers, 1 means the y sign steers) and stays fixed for the whole run.
- R10: busy and step_valid rise in the clock after an accepted start and stay high through the high phase of the last word. done is a single-clock pulse in the following clock, with busy low.
- R11: A start pulse while busy is ignored. The run in progress continues unchanged, including its mode and sign_y.
- R12: A start with func[1:0] = 11 is ignored: busy stays 0 and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| func | input | 3 | [2] vectoring, [1:0] mode code |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse after the final word |
| step_valid | output | 1 | A step command is being presented |
| step_kind | output | 2 | 00 regular, 01 double, 10 scale |
| step_idx | output | $clog2(ITERS+1) | Iteration index i of the current step |
| step_phase | output | 1 | 0 low half-word pass, 1 high half-word pass |
| step_last | output | 1 | Current word is the final one |
| sign_y | output | 1 | 1 steer from y sign, 0 steer from z sign |

## Verification
A behavioural reference builds the expected step list for each mode from the insertion rules and checks the outputs on every clock. The three modes are run in turn. The linear run shows that the index counts without gaps. The circular run separates scale insertion from index advance. The hyperbolic run shows that double and scale words reuse the index and come in the right order. A rotation and a vectoring run tell the two sign sources apart. A competing start in mid-run, a start with the unused mode code, and a restart in the done clock check that start is accepted only from idle and only with a valid code.

// File: rtl/cseq_pkg.sv
// Shared types and ROM-content generation for the CORDIC step sequencer.
// Assumes ITERS stays below 32 and the longest program fits 128 words.
package cseq_pkg;

    typedef enum logic [1:0] {
        STEP_REG = 2'b00,
        STEP_DBL = 2'b01,
        STEP_SCL = 2'b10
    } step_kind_e;

    localparam logic [1:0] MODE_LIN  = 2'b00;
    localparam logic [1:0] MODE_CIRC = 2'b01;
    localparam logic [1:0] MODE_HYP  = 2'b10;
    localparam int MAX_ITERS = 31;

    // Indices that take an extra double step
    function automatic bit takes_double(logic [1:0] mode, int i);
        return (mode == MODE_HYP) && (i == 4 || i == 13);
    endfunction

    // Indices that take an extra scale-factor step
    function automatic bit takes_scale(logic [1:0] mode, int i);
        if (mode == MODE_CIRC) return (i == 2 || i == 4);
        if (mode == MODE_HYP)  return (i == 3 || i == 5);
        return 1'b0;
    endfunction

    // Number of words in a mode's program
    function automatic int prog_words(logic [1:0] mode, int iters);
        int n;
        n = 0;
        for (int i = 1; i <= MAX_ITERS; i++) begin
            if (i <= iters) begin
                n = n + 1;
                if (takes_double(mode, i)) n = n + 1;
                if (takes_scale(mode, i))  n = n + 1;
            end
        end
        return n;
    endfunction

    // Microword at offset k of a sector: [1:0] kind, [2] last, rest zero
    function automatic logic [15:0] word_at(logic [1:0] mode, int k, int iters);
        logic [15:0] w;
        int pos;
        w = '0;
        pos = 0;
        for (int i = 1; i <= MAX_ITERS; i++) begin
            if (i <= iters) begin
                if (pos == k) w[1:0] = STEP_REG;
                pos = pos + 1;
                if (takes_double(mode, i)) begin
                    if (pos == k) w[1:0] = STEP_DBL;
                    pos = pos + 1;
                end
                if (takes_scale(mode, i)) begin
                    if (pos == k) w[1:0] = STEP_SCL;
                    pos = pos + 1;
                end
            end
        end
        if (k >= prog_words(mode, iters) - 1) w[2] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/cseq_rom.sv
// Microcode ROM: a constant table filled at elaboration from the per-mode
// insertion lists. The upper address bits are the sector (mode code).
module cseq_rom #(
    parameter int ITERS = 24,
    parameter int UAW   = 7,
    parameter int WW    = 16
) (
    input  logic [UAW+1:0] addr,
    output logic [1:0]     kind,
    output logic           last
);
    import cseq_pkg::*;

    localparam int AW    = UAW + 2;
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] tbl [DEPTH];
    logic [WW-1:0] word;

    // One constant entry per address
    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        assign tbl[a] = WW'(word_at(2'(a >> UAW), a % (1 << UAW), ITERS));
    end

    // Table read and field split
    always_comb begin
        word = tbl[addr];
        kind = word[1:0];
        last = word[2];
    end
endmodule

// File: rtl/cseq_ctrl.sv
// Run control: accepts start from idle, walks the micro-address, paces
// the two half-word phases and counts regular steps for the index.
module cseq_ctrl #(
    parameter int UAW  = 7,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      func,
    input  logic [1:0]      word_kind,
    input  logic            word_last,
    output logic [UAW+1:0]  addr,
    output logic            busy,
    output logic            done,
    output logic            phase,
    output logic            sign_y,
    output logic [IDXW-1:0] idx
);
    import cseq_pkg::*;

    logic [UAW-1:0]  uaddr;
    logic [1:0]      mode;
    logic [IDXW-1:0] reg_cnt;
    logic            is_reg;

    // Sequencing registers: start capture, phase toggle, address and index advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            phase   <= 1'b0;
            uaddr   <= '0;
            mode    <= MODE_LIN;
            sign_y  <= 1'b0;
            reg_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start && func[1:0] != 2'b11) begin
                    busy    <= 1'b1;
                    mode    <= func[1:0];
                    sign_y  <= func[2];
                    uaddr   <= '0;
                    phase   <= 1'b0;
                    reg_cnt <= '0;
                end
            end else if (!phase) begin
                phase <= 1'b1;
            end else begin
                phase <= 1'b0;
                if (word_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    uaddr <= uaddr + UAW'(1);
                    if (is_reg) reg_cnt <= reg_cnt + IDXW'(1);
                end
            end
        end
    end

    // Address composition and index presentation
    always_comb begin
        is_reg = (word_kind == STEP_REG);
        addr   = {mode, uaddr};
        idx    = busy ? reg_cnt + IDXW'(is_reg) : '0;
    end
endmodule

// File: rtl/cordic_step_seq.sv
// Top of the CORDIC step sequencer: ROM plus run control. Outputs are
// zeroed while idle. Assumes the datapath consumes one phase per clock.
module cordic_step_seq #(
    parameter int ITERS = 24,
    localparam int IDXW = $clog2(ITERS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      func,
    output logic            busy,
    output logic            done,
    output logic            step_valid,
    output logic [1:0]      step_kind,
    output logic [IDXW-1:0] step_idx,
    output logic            step_phase,
    output logic            step_last,
    output logic            sign_y
);
    localparam int UAW = 7;

    logic [UAW+1:0] addr;
    logic [1:0]     rom_kind;
    logic           rom_last;
    logic           phase_q;

    cseq_rom #(.ITERS(ITERS), .UAW(UAW), .WW(16)) u_rom (
        .addr (addr),
        .kind (rom_kind),
        .last (rom_last)
    );

    cseq_ctrl #(.UAW(UAW), .IDXW(IDXW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .func      (func),
        .word_kind (rom_kind),
        .word_last (rom_last),
        .addr      (addr),
        .busy      (busy),
        .done      (done),
        .phase     (phase_q),
        .sign_y    (sign_y),
        .idx       (step_idx)
    );

    // Gate step fields to zero outside a run
    always_comb begin
        step_valid = busy;
        step_kind  = busy ? rom_kind : 2'b00;
        step_phase = busy & phase_q;
        step_last  = busy & rom_last;
    end
endmodule

// File: rtl/cseq_chk.sv
// Property checker for the step sequencer, attached by bind.
module cseq_chk #(
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic [1:0]      step_kind,
    input logic [IDXW-1:0] step_idx,
    input logic            step_phase,
    input logic            step_last,
    input logic            sign_y
);
    // Low phase is always followed by the high phase of the same word
    assert_phase_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_phase) |=> (busy && step_phase));

    // Kind and index hold across the two phases of a word
    assert_word_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_phase) |=> ($stable(step_kind) && $stable(step_idx)));

    // Encoding 11 never presented
    assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_kind != 2'b11));

    // Final high phase ends the run with a done pulse
    assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step_last && step_phase) |=> (!busy && done));

    // done is a lone pulse outside busy
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // Run continues until the final word, whatever start does
    assert_run_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(step_last && step_phase)) |=> busy);

    // Sign source fixed within a run
    assert_sign_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(step_last && step_phase)) |=> $stable(sign_y));
endmodule

bind cordic_step_seq cseq_chk #(.IDXW(IDXW)) u_cseq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .step_kind  (step_kind),
    .step_idx   (step_idx),
    .step_phase (step_phase),
    .step_last  (step_last),
    .sign_y     (sign_y)
);

// File: tb/test_cordic_step_seq.sv
`timescale 1ns/1ps
module test_cordic_step_seq;
    localparam int ITERS = 24;
    localparam int IDXW  = $clog2(ITERS + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [2:0]      func = 3'b000;
    logic            busy, done, step_valid, step_phase, step_last, sign_y;
    logic [1:0]      step_kind;
    logic [IDXW-1:0] step_idx;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct { int kind; int idx; int ph; bit last; } ent_t;
    ent_t q[$];
    bit m_busy = 0;
    bit m_done = 0;
    bit m_sign = 0;

    always #2.5 clk = ~clk;

    cordic_step_seq #(.ITERS(ITERS)) i_cordic_step_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .busy(busy), .done(done), .step_valid(step_valid),
        .step_kind(step_kind), .step_idx(step_idx), .step_phase(step_phase),
        .step_last(step_last), .sign_y(sign_y)
    );

    // Expected word lists from the insertion rules (R5, R6, R7)
    function automatic bit want_dbl(int m, int i);
        return m == 2 && (i == 4 || i == 13);
    endfunction
    function automatic bit want_scl(int m, int i);
        return (m == 1 && (i == 2 || i == 4)) || (m == 2 && (i == 3 || i == 5));
    endfunction

    task automatic push_word(int k, int i);
        ent_t e;
        e.kind = k; e.idx = i; e.last = 0;
        e.ph = 0; q.push_back(e);
        e.ph = 1; q.push_back(e);
    endtask

    task automatic build(int m);
        q.delete();
        for (int i = 1; i <= ITERS; i++) begin
            push_word(0, i);
            if (want_dbl(m, i)) push_word(1, i);
            if (want_scl(m, i)) push_word(2, i);
        end
        q[q.size()-1].last = 1;
        q[q.size()-2].last = 1;
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete(); m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                void'(q.pop_front());
                if (q.size() == 0) begin m_busy = 0; m_done = 1; end
            end else if (start && func[1:0] != 2'b11) begin
                build(int'(func[1:0]));
                m_busy = 1;
                m_sign = func[2];
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Compare every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == m_busy, "R10 busy", int'(busy), int'(m_busy));
            chk(step_valid == m_busy, "R10 step_valid", int'(step_valid), int'(m_busy));
            chk(done == m_done, "R10 done", int'(done), int'(m_done));
            if (m_busy && q.size() > 0) begin
                chk(int'(step_kind) == q[0].kind, "R2/R5/R6/R7 kind", int'(step_kind), q[0].kind);
                chk(int'(step_idx) == q[0].idx, "R4 index", int'(step_idx), q[0].idx);
                chk(int'(step_phase) == q[0].ph, "R3 phase", int'(step_phase), q[0].ph);
                chk(step_last == q[0].last, "R8 last", int'(step_last), int'(q[0].last));
                chk(sign_y == m_sign, "R9 sign", int'(sign_y), int'(m_sign));
            end else begin
                chk(step_idx == '0, "R1 idle index", int'(step_idx), 0);
                chk(step_last == 1'b0, "R1 idle last", int'(step_last), 0);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL R10 watchdog expired: actual %0d expected <= 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic go(logic [2:0] f);
        @(negedge clk); func = f; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && step_valid == 0, "R1 reset flags", int'({busy, done, step_valid}), 0);
        chk(step_idx == '0 && step_phase == 0, "R1 reset index/phase", int'(step_idx), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        go(3'b000);            // R5 linear rotation (z sign)
        wait_idle();
        go(3'b101);            // R6 circular vectoring (y sign)
        wait_idle();
        go(3'b010);            // R7 hyperbolic rotation
        wait_idle();

        // R11: competing start in mid-run
        go(3'b100);
        repeat (9) @(negedge clk);
        func = 3'b110; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle();

        // R12: unused mode code ignored
        go(3'b011);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R12 unused code", int'(busy), 0);
        go(3'b111);
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R12 unused code vectoring", int'({busy, done}), 0);

        // R10: restart in the done clock
        go(3'b001);
        while (!done) @(negedge clk);
        func = 3'b110; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_idle();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule